// File: doc/BRIEF.md
# GPIO Bank with Change Interrupts

This block is an eight-pin general-purpose I/O bank. A host reaches it over a plain byte-wide register bus: a 4-bit address, write data with a write strobe, and a read strobe with combinational read data. Four registers set the pins up. One holds the pin directions. One holds the output levels and reports the pin levels. One enables interrupts per pin. One holds the mode and a self-clearing reset. The bank drives an output-enable and an output value for each pin. It samples the pad levels through a two-flop synchroniser.

When an input pin with its enable bit set changes level, the bank pulls its active-low interrupt line. The capture mode sets how that pending change is held. In non-latched mode the pending state follows the pin and drops if the pin returns to its former level. In latched mode the new level is frozen into the state register view and the interrupt is held until the host reads the state register. A read of the state register clears pending changes. So does any write to the direction register.

Top module: `gpio_chg_bank`

## Requirements
- R1: Registers decode at direction = 0x0A, state = 0x0B, interrupt enable = 0x0C and control = 0x0E. Every other address in 0x00..0x0F reads as 0x00, and writes there change no register.
- R2: Direction bit n drives pin_oe[n] (1 = output, 0 = input). A write to the state register sets pin_out, and the output pins take that level.
- R3: A read of the state register returns the level of all eight pins. A pin change shows up in the read data two clock edges after it reaches pin_in.
- R4: A change on a pin whose interrupt-enable bit is 0, or on a pin configured as output, leaves irq_n high.
- R5: With control bit 0 = 0 (non-latched mode), an enabled input change drives irq_n low on the third rising edge after the change. If the pin returns to its earlier level before a read, irq_n goes high again.
- R6: In non-latched mode, a read of the state register (0x0B) releases irq_n on the edge that ends the read.
- R7: With control bit 0 = 1 (latched mode), irq_n stays low and the state bit keeps the level that caused the change, even after the pin reverts. The next state read returns that captured level and releases irq_n. The read after it returns the live level.
- R8: Any write to the direction register clears the interrupts that are already pending.
- R9: Writing control with bit 3 = 1 resets the bank. Direction, interrupt enable and control go to 0, irq_n goes high, and bit 3 reads back 0.
- R10: Control bits 7:4 and 2:1 always read as 0.
- R11: If another enabled pin's change becomes visible in the same cycle as a clearing state read, that pin stays pending and irq_n stays low.
- R12: After hardware reset all pins are inputs, irq_n is high, and the direction, interrupt-enable and control registers read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe; a state read clears pending changes |
| rdata | output | 8 | Read data, valid while rd_en is high |
| pin_in | input | 8 | Pad levels, asynchronous |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output level |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the bank with its defaults: eight pins and a two-stage synchroniser. The bench's pad model feeds the output pins back into pin_in, so one state read can mix driven and external levels. With the two-stage synchroniser the interrupt latency is exactly three edges. The bench can therefore place a second pin's change so that it becomes visible in the same cycle as the clearing read, which is the race R11 covers.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int unsigned REG_AW = 4;
  localparam logic [REG_AW-1:0] A_DIR   = 4'hA;
  localparam logic [REG_AW-1:0] A_STATE = 4'hB;
  localparam logic [REG_AW-1:0] A_IEN   = 4'hC;
  localparam logic [REG_AW-1:0] A_CTRL  = 4'hE;
  localparam int unsigned CTRL_LATCH_BIT = 0;
  localparam int unsigned CTRL_SRST_BIT  = 3;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st[s] <= '0;
      else if (s == 0) st[s] <= d;
      else             st[s] <= st[(s == 0) ? 0 : s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_chg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_dir,
  input  logic              wr_state,
  input  logic              wr_ien,
  input  logic              wr_ctrl,
  input  logic              srst,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      ien_q,
  output logic              latch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      latch_q <= 1'b0;
    end else if (srst) begin
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      latch_q <= 1'b0;
    end else begin
      if (wr_dir)   dir_q   <= wdata;
      if (wr_state) out_q   <= wdata;
      if (wr_ien)   ien_q   <= wdata;
      if (wr_ctrl)  latch_q <= wdata[CTRL_LATCH_BIT];
    end
  end

  // R9: the self-clearing reset empties every configuration register
  assert_srst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (dir_q == '0) && (ien_q == '0) && !latch_q);
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_in,
  input  logic [W-1:0] en,
  input  logic         latch,
  input  logic         clr,
  input  logic         kill,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] view
);
  logic [W-1:0] ref_q, hit, fresh, pend_n, ref_n;

  function automatic logic [W-1:0] next_pend(
    input logic [W-1:0] pend, input logic [W-1:0] h, input logic [W-1:0] f,
    input logic [W-1:0] e, input logic lt, input logic cl, input logic kl);
    if (kl)      return '0;
    else if (cl) return f;
    else if (lt) return (pend | h) & e;
    else         return h;
  endfunction

  assign hit    = (sync_in ^ ref_q) & en;
  assign fresh  = hit & ~pend_q;
  assign pend_n = next_pend(pend_q, hit, fresh, en, latch, clr, kill);
  assign ref_n  = (pend_n & ref_q) | (~pend_n & sync_in);
  assign view   = latch ? ((pend_q & ~ref_q) | (~pend_q & sync_in)) : sync_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      pend_q <= '0;
    end else begin
      ref_q  <= ref_n;
      pend_q <= pend_n;
    end
  end

  // R7: in latched mode a pending enabled change survives until a clear
  assert_latched_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    latch && !clr && !kill |=> ($past(pend_q & en) & ~pend_q) == '0);

  // R6 / R8: a clearing event drops every bit that was already pending
  assert_clear_drops_old_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !kill |=> (pend_q & $past(pend_q)) == '0);
endmodule

// File: rtl/gpio_chg_bank.sv
module gpio_chg_bank
  import gpio_chg_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_oe,
  output logic [W-1:0]      pin_out,
  output logic              irq_n
);
  logic [W-1:0] sync_in, dir_q, out_q, ien_q, pend_q, view, en;
  logic         latch_q;
  logic         wr_dir, wr_state, wr_ien, wr_ctrl, srst, rd_state, clr;

  assign wr_dir   = wr_en && (addr == A_DIR);
  assign wr_state = wr_en && (addr == A_STATE);
  assign wr_ien   = wr_en && (addr == A_IEN);
  assign wr_ctrl  = wr_en && (addr == A_CTRL);
  assign srst     = wr_ctrl && wdata[CTRL_SRST_BIT];
  assign rd_state = rd_en && (addr == A_STATE);
  assign clr      = rd_state || wr_dir;
  assign en       = ien_q & ~dir_q;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_in));

  gpio_ctl_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_state(wr_state),
    .wr_ien(wr_ien), .wr_ctrl(wr_ctrl), .srst(srst), .wdata(wdata),
    .dir_q(dir_q), .out_q(out_q), .ien_q(ien_q), .latch_q(latch_q));

  gpio_chg_detect #(.W(W)) u_det (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .en(en), .latch(latch_q),
    .clr(clr), .kill(srst), .pend_q(pend_q), .view(view));

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        A_DIR:   rdata = dir_q;
        A_STATE: rdata = view;
        A_IEN:   rdata = ien_q;
        A_CTRL:  rdata = W'(latch_q);
        default: rdata = '0;
      endcase
    end
  end

  assign pin_oe  = dir_q;
  assign pin_out = out_q;
  assign irq_n   = ~|(pend_q & en);

  // R2: a direction write lands on the output enables one edge later
  assert_oe_follows_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pin_oe == $past(wdata));

  // R9: software reset releases the interrupt and turns all pins to inputs
  assert_srst_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (pin_oe == '0) && irq_n);

  // R4: the interrupt needs at least one enabled input pin
  assert_irq_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> |(ien_q & ~dir_q));

  // R10: reserved control bits read as zero
  assert_ctrl_reserved_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == A_CTRL) |-> rdata[W-1:1] == '0);
endmodule

// File: tb/gpio_chg_bank_test.sv
module gpio_chg_bank_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata, pin_oe, pin_out, pin_in;
  logic       irq_n;
  logic [7:0] ext = '0;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  // pad model: driven pins read back their own level
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_chg_bank uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe),
    .pin_out(pin_out), .irq_n(irq_n));

  // {write?, address, write data, expected read}
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 4'hA, 8'h5A, 8'h5A},
    {1'b1, 4'hC, 8'h33, 8'h33},
    {1'b1, 4'hE, 8'hF7, 8'h01},
    {1'b1, 4'hE, 8'h00, 8'h00},
    {1'b1, 4'h0, 8'hFF, 8'h00},
    {1'b1, 4'hF, 8'hFF, 8'h00},
    {1'b1, 4'h9, 8'h12, 8'h00},
    {1'b0, 4'hA, 8'h00, 8'h5A},
    {1'b1, 4'hA, 8'h00, 8'h00},
    {1'b1, 4'hC, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
    addr = a; rd_en = 1'b1;
    #2;
    check(req, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual 00 expected 01");
    finish_run();
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    // R12: reset state
    check("R12 irq", {7'b0, irq_n}, 8'h01);
    check("R12 oe", pin_oe, 8'h00);
    rd("R12 dir", 4'hA, 8'h00);
    rd("R12 ctrl", 4'hE, 8'h00);

    // R1 R10: register table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) wr(VEC[i][19:16], VEC[i][15:8]);
      rd("R1 R10 table", VEC[i][19:16], VEC[i][7:0]);
    end

    // R2 R3: mixed outputs and inputs
    ext = 8'h3C;
    wr(4'hA, 8'hF0);
    wr(4'hB, 8'hA0);
    check("R2 oe", pin_oe, 8'hF0);
    check("R2 out", pin_out, 8'hA0);
    idle(3);
    rd("R3 mixed", 4'hB, 8'hAC);
    wr(4'hA, 8'h00);

    // R4: change with enables off
    ext = 8'h3D;
    idle(4);
    check("R4 irq", {7'b0, irq_n}, 8'h01);
    rd("R3 input", 4'hB, 8'h3D);

    // R5 R6: non-latched
    wr(4'hC, 8'hFF);
    idle(2);
    check("R5 quiet", {7'b0, irq_n}, 8'h01);
    ext = 8'h3F;
    idle(2);
    check("R5 latency", {7'b0, irq_n}, 8'h01);
    idle(1);
    check("R5 raise", {7'b0, irq_n}, 8'h00);
    ext = 8'h3D;
    idle(3);
    check("R5 revert", {7'b0, irq_n}, 8'h01);
    ext = 8'h39;
    idle(3);
    check("R6 raise", {7'b0, irq_n}, 8'h00);
    rd("R6 read", 4'hB, 8'h39);
    check("R6 clear", {7'b0, irq_n}, 8'h01);

    // R8: direction write clears pending
    ext = 8'h19;
    idle(3);
    check("R8 raise", {7'b0, irq_n}, 8'h00);
    wr(4'hA, 8'h00);
    check("R8 clear", {7'b0, irq_n}, 8'h01);

    // R7: latched mode
    ext = 8'h00;
    idle(4);
    rd("R7 settle", 4'hB, 8'h00);
    wr(4'hE, 8'h01);
    ext = 8'h10;
    idle(3);
    check("R7 raise", {7'b0, irq_n}, 8'h00);
    ext = 8'h00;
    idle(4);
    check("R7 hold", {7'b0, irq_n}, 8'h00);
    rd("R7 captured", 4'hB, 8'h10);
    check("R7 clear", {7'b0, irq_n}, 8'h01);
    rd("R7 live", 4'hB, 8'h00);

    // R11: second change meets the clearing read
    ext = 8'h40;
    idle(3);
    check("R11 first", {7'b0, irq_n}, 8'h00);
    ext = 8'hC0;
    idle(2);
    rd("R11 read", 4'hB, 8'hC0);
    check("R11 kept", {7'b0, irq_n}, 8'h00);
    rd("R11 reread", 4'hB, 8'hC0);
    check("R11 clear", {7'b0, irq_n}, 8'h01);

    // R9: software reset
    wr(4'hA, 8'h0F);
    ext = 8'h80;
    idle(3);
    check("R9 pending", {7'b0, irq_n}, 8'h00);
    wr(4'hE, 8'h08);
    check("R9 irq", {7'b0, irq_n}, 8'h01);
    check("R9 oe", pin_oe, 8'h00);
    rd("R9 dir", 4'hA, 8'h00);
    rd("R9 ien", 4'hC, 8'h00);
    rd("R9 ctrl", 4'hE, 8'h00);

    // R12: hardware reset mid-run
    wr(4'hA, 8'hFF);
    wr(4'hC, 8'hFF);
    rst_n = 1'b0;
    #2;
    check("R12 hw oe", pin_oe, 8'h00);
    check("R12 hw irq", {7'b0, irq_n}, 8'h01);
    idle(1);
    rst_n = 1'b1;
    idle(1);
    rd("R12 hw ien", 4'hC, 8'h00);

    finish_run();
  end
endmodule